// File: doc/BRIEF.md
# Buffered Serial Transmitter

This block turns parallel characters into an asynchronous serial stream. Characters enter through a valid/ready write port into a small queue. The queue feeds a shift register that sends each frame on a single output line. The frame is a start bit, then the data bits, an optional parity bit and one or two stop bits. Bit timing comes from an external baud generator: it gives a one-cycle strobe, and the current bit is held until that strobe arrives.

Software picks the character format, the stop-bit count, the idle polarity of the line and the event that raises the transmit interrupt. A break command sends a frame that holds the line at its active level for the length of a long character. Dropping the enable stops the transmitter at once and throws away everything that is queued.

The write port obeys standard valid/ready rules. A character moves only on a clock edge where both `wr_valid` and `wr_ready` are high. `wr_ready` is low while the queue is full or while the transmitter is disabled. A producer may hold `wr_valid` and data steady for as long as it likes, and nothing moves until `wr_ready` returns.

Top module: `ser_tx_buffered`

## Requirements
- R1: The queue holds up to DEPTH (default 4) characters on top of the one being shifted. `buf_full` is high exactly when DEPTH characters are waiting. `wr_ready` equals `tx_en` and not `buf_full`.
- R2: A write offered while the queue is full is not taken. The characters already stored go out unchanged and in their original order.
- R3: `shift_empty` is 1 only when no frame is being shifted, no character is queued and the line has returned to idle.
- R4: `frame_fmt` selects the character format. 00 means 8 data bits and no parity. 01 means 8 bits and even parity. 10 means 8 bits and odd parity. 11 means 9 data bits (`wr_data[8]` sent last) and no parity. Data goes out least significant bit first, after a 0 start bit. The parity bit comes after the data bits.
- R5: `two_stop` = 0 sends one stop bit at level 1. `two_stop` = 1 sends two. Format and stop count are taken when a character enters the shift register.
- R6: Each bit stays on the line until a `bit_tick` strobe ends it. A character enters the shift register on the edge after it becomes eligible, and its start bit appears in the next cycle.
- R7: `tx_irq` is a one-cycle pulse whose trigger depends on `irq_mode`. 00 fires when a character moves from the queue into the shift register. 01 fires when a frame ends with nothing queued, no character written on that edge and no break pending. 10 fires when a move empties the queue and no write arrives on the same edge. 11 adds no event.
- R8: A rising `tx_en` raises `tx_irq` two clock edges later, whatever `irq_mode` is.
- R9: A `brk_go` pulse sets `brk_busy`. When the shifter is free, the break frame goes out ahead of any queued character. It is one start bit, twelve 0 bits and one stop bit. `brk_busy` clears by itself at the end of that frame.
- R10: While `tx_en` is 0, the frame in progress is abandoned, the queue is emptied and any pending break is dropped, all on the next edge.
- R11: With `idle_inv` = 1 every line level is inverted, so the idle line sits at 0. With `idle_inv` = 0 it sits at 1.
- R12: After reset the line is idle, `shift_empty` is 1, and `buf_full`, `tx_irq` and `brk_busy` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmitter enable; low aborts and flushes |
| frame_fmt | input | 2 | Character format select |
| two_stop | input | 1 | Two stop bits when 1 |
| idle_inv | input | 1 | Inverts the line polarity |
| irq_mode | input | 2 | Interrupt trigger select |
| brk_go | input | 1 | Pulse requesting a break frame |
| bit_tick | input | 1 | One-cycle baud strobe |
| wr_valid | input | 1 | Write request |
| wr_data | input | 9 | Character to send |
| wr_ready | output | 1 | Queue can take a character |
| buf_full | output | 1 | Queue is full |
| shift_empty | output | 1 | All transmission finished |
| brk_busy | output | 1 | Break requested or in progress |
| tx_irq | output | 1 | Transmit interrupt pulse |
| txd | output | 1 | Serial output line |

## Verification
Two events can fall on the same edge: the final `bit_tick` of a frame with nothing queued, and a write accepted by the queue. In completion mode the write must suppress the interrupt, because the transmitter is not finished.

To provoke the collision, the bench uses a strobe on every cycle and sends pairs of characters, stepping the gap between the two writes through a range of delays. Some of those gaps land the second write exactly on the closing edge. A behavioural queue-and-bit-list model predicts `tx_irq`, `shift_empty` and `txd` for every cycle. The design's outputs are compared against that model on every clock.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  localparam int CHAR_W = 9;

  typedef enum logic [1:0] {
    FMT_8N = 2'b00,
    FMT_8E = 2'b01,
    FMT_8O = 2'b10,
    FMT_9N = 2'b11
  } fmt_e;

  typedef enum logic [1:0] {
    IRQ_ON_LOAD      = 2'b00,
    IRQ_ON_DRAIN     = 2'b01,
    IRQ_ON_LAST_LOAD = 2'b10,
    IRQ_NONE         = 2'b11
  } irq_mode_e;
endpackage

// File: rtl/ser_tx_fifo.sv
module ser_tx_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 9,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= step(wptr);
      if (pop)  rptr <= step(rptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= din;
  end

  assign dout  = mem[rptr];
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
endmodule

// File: rtl/ser_tx_shifter.sv
module ser_tx_shifter
  import ser_tx_pkg::*;
#(
  parameter int BRK_ZEROS = 12,
  localparam int FRAME_W  = BRK_ZEROS + 2,
  localparam int LEN_W    = $clog2(FRAME_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              load,
  input  logic              load_brk,
  input  logic [CHAR_W-1:0] din,
  input  fmt_e              fmt,
  input  logic              two_stop,
  input  logic              tick,
  output logic              busy,
  output logic              line,
  output logic              done,
  output logic              cur_brk
);
  logic [FRAME_W-1:0] shreg, nvec;
  logic [LEN_W-1:0]   rem, nlen;

  // Whole frame is laid out at load time; the line is always bit 0.
  always_comb begin
    nvec = '1;
    nlen = LEN_W'(10);
    if (load_brk) begin
      nvec              = '0;
      nvec[FRAME_W-1]   = 1'b1;
      nlen              = LEN_W'(FRAME_W);
    end else begin
      nvec[0]   = 1'b0;
      nvec[8:1] = din[7:0];
      case (fmt)
        FMT_8N: begin nvec[9] = 1'b1;       nlen = LEN_W'(10); end
        FMT_8E: begin nvec[9] = ^din[7:0];  nlen = LEN_W'(11); end
        FMT_8O: begin nvec[9] = ~^din[7:0]; nlen = LEN_W'(11); end
        default: begin nvec[9] = din[8];    nlen = LEN_W'(11); end
      endcase
      if (two_stop) nlen = nlen + 1'b1;
    end
  end

  assign done = busy && tick && (rem == LEN_W'(1));
  assign line = busy ? shreg[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n || abort) begin
      busy    <= 1'b0;
      shreg   <= '1;
      rem     <= '0;
      cur_brk <= 1'b0;
    end else if (load) begin
      busy    <= 1'b1;
      shreg   <= nvec;
      rem     <= nlen;
      cur_brk <= load_brk;
    end else if (busy && tick) begin
      shreg <= {1'b1, shreg[FRAME_W-1:1]};
      rem   <= rem - 1'b1;
      if (done) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/ser_tx_irq.sv
module ser_tx_irq
  import ser_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tx_en,
  input  irq_mode_e mode,
  input  logic      load_data,
  input  logic      last_load,
  input  logic      done,
  input  logic      drained,
  output logic      irq
);
  logic en_q1, en_q2, evt;

  always_comb begin
    case (mode)
      IRQ_ON_LOAD:      evt = load_data;
      IRQ_ON_DRAIN:     evt = done && drained;
      IRQ_ON_LAST_LOAD: evt = load_data && last_load;
      default:          evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q1 <= 1'b0;
      en_q2 <= 1'b0;
      irq   <= 1'b0;
    end else begin
      en_q1 <= tx_en;
      en_q2 <= en_q1;
      irq   <= (en_q1 && !en_q2) || (tx_en && evt);
    end
  end
endmodule

// File: rtl/ser_tx_buffered.sv
module ser_tx_buffered
  import ser_tx_pkg::*;
#(
  parameter int DEPTH     = 4,
  parameter int BRK_ZEROS = 12,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic [1:0]        frame_fmt,
  input  logic              two_stop,
  input  logic              idle_inv,
  input  logic [1:0]        irq_mode,
  input  logic              brk_go,
  input  logic              bit_tick,
  input  logic              wr_valid,
  input  logic [CHAR_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              buf_full,
  output logic              shift_empty,
  output logic              brk_busy,
  output logic              tx_irq,
  output logic              txd
);
  logic [CHAR_W-1:0] q_head;
  logic [CW-1:0]     q_count;
  logic              q_empty, push_fire, pop_fire;
  logic              sh_busy, sh_line, sh_done, sh_brk;
  logic              load, load_brk, brk_pend;

  assign wr_ready  = tx_en && !buf_full;
  assign push_fire = wr_valid && wr_ready;
  assign load      = tx_en && !sh_busy && (brk_pend || !q_empty);
  assign load_brk  = load && brk_pend;
  assign pop_fire  = load && !brk_pend;

  ser_tx_fifo #(.DEPTH(DEPTH), .W(CHAR_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(!tx_en),
    .push(push_fire), .pop(pop_fire), .din(wr_data),
    .dout(q_head), .count(q_count), .full(buf_full), .empty(q_empty)
  );

  ser_tx_shifter #(.BRK_ZEROS(BRK_ZEROS)) u_shift (
    .clk(clk), .rst_n(rst_n), .abort(!tx_en),
    .load(load), .load_brk(load_brk), .din(q_head),
    .fmt(fmt_e'(frame_fmt)), .two_stop(two_stop), .tick(bit_tick),
    .busy(sh_busy), .line(sh_line), .done(sh_done), .cur_brk(sh_brk)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !tx_en) brk_pend <= 1'b0;
    else if (brk_go)      brk_pend <= 1'b1;
    else if (sh_done && sh_brk) brk_pend <= 1'b0;
  end

  ser_tx_irq u_irq (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en),
    .mode(irq_mode_e'(irq_mode)),
    .load_data(pop_fire),
    .last_load((q_count == CW'(1)) && !push_fire),
    .done(sh_done),
    .drained(q_empty && !push_fire && (sh_brk || !brk_pend)),
    .irq(tx_irq)
  );

  assign brk_busy    = brk_pend;
  assign shift_empty = !sh_busy && q_empty;
  assign txd         = sh_line ^ idle_inv;
endmodule

// File: rtl/ser_tx_buffered_chk.sv
module ser_tx_buffered_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic idle_inv,
  input logic txd,
  input logic shift_empty,
  input logic brk_busy,
  input logic buf_full,
  input logic tx_irq,
  input logic sh_busy,
  input logic pop_fire
);
  assert_idle_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
    shift_empty |-> (txd == !idle_inv));

  assert_start_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sh_busy) |-> (txd == idle_inv));

  assert_full_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_full && !pop_fire && tx_en) |=> buf_full);

  assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (shift_empty && !brk_busy));

  assert_enable_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> ##2 tx_irq);
endmodule

bind ser_tx_buffered ser_tx_buffered_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .idle_inv(idle_inv),
  .txd(txd), .shift_empty(shift_empty), .brk_busy(brk_busy),
  .buf_full(buf_full), .tx_irq(tx_irq), .sh_busy(sh_busy),
  .pop_fire(pop_fire)
);

// File: tb/tb_ser_tx_buffered.sv
module tb_ser_tx_buffered;
  logic clk = 1'b0;
  logic rst_n, tx_en, two_stop, idle_inv, brk_go, bit_tick, wr_valid;
  logic [1:0] frame_fmt, irq_mode;
  logic [8:0] wr_data;
  logic wr_ready, buf_full, shift_empty, brk_busy, tx_irq, txd;

  int checks = 0, fails = 0, cycles = 0, tick_div = 3, tick_cnt = 0;
  bit finished = 0;
  string phase = "R12 reset";

  always #5 clk = ~clk;

  ser_tx_buffered dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .frame_fmt(frame_fmt),
    .two_stop(two_stop), .idle_inv(idle_inv), .irq_mode(irq_mode),
    .brk_go(brk_go), .bit_tick(bit_tick), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_ready(wr_ready), .buf_full(buf_full),
    .shift_empty(shift_empty), .brk_busy(brk_busy), .tx_irq(tx_irq),
    .txd(txd)
  );

  // baud strobe
  always @(negedge clk) begin
    if (tick_cnt >= tick_div - 1) begin bit_tick <= 1'b1; tick_cnt <= 0; end
    else begin bit_tick <= 1'b0; tick_cnt <= tick_cnt + 1; end
  end

  // behavioural reference model
  logic [8:0] mq[$];
  bit mbits[$];
  bit mbusy, mbrk, mpend, men1, men2, mirq;

  always @(posedge clk) begin
    int sz;
    bit push, ld, ldb, done, evt;
    logic [8:0] d;
    if (!rst_n) begin
      mq.delete(); mbits.delete();
      mbusy = 0; mbrk = 0; mpend = 0; men1 = 0; men2 = 0; mirq = 0;
    end else begin
      sz   = mq.size();
      push = tx_en && wr_valid && (sz < 4);
      done = mbusy && bit_tick && (mbits.size() == 1);
      ld   = tx_en && !mbusy && (mpend || sz > 0);
      ldb  = ld && mpend;
      evt  = 0;
      if (tx_en) begin
        if (irq_mode == 2'b00) evt = ld && !ldb;
        if (irq_mode == 2'b10) evt = ld && !ldb && (sz == 1) && !push;
        if (irq_mode == 2'b01) evt = done && (sz == 0) && !push && (mbrk || !mpend);
      end
      mirq = (men1 && !men2) || evt;
      men2 = men1;
      men1 = tx_en;
      if (!tx_en) begin
        mq.delete(); mbits.delete(); mbusy = 0; mbrk = 0; mpend = 0;
      end else begin
        if (mbusy && bit_tick) begin
          void'(mbits.pop_front());
          if (mbits.size() == 0) mbusy = 0;
        end
        if (brk_go) mpend = 1;
        else if (done && mbrk) mpend = 0;
        if (ld) begin
          mbits.delete();
          mbits.push_back(1'b0);
          if (ldb) begin
            for (int i = 0; i < 12; i++) mbits.push_back(1'b0);
            mbits.push_back(1'b1);
            mbrk = 1;
          end else begin
            d = mq.pop_front();
            for (int i = 0; i < 8; i++) mbits.push_back(d[i]);
            if (frame_fmt == 2'b01) mbits.push_back(^d[7:0]);
            if (frame_fmt == 2'b10) mbits.push_back(~^d[7:0]);
            if (frame_fmt == 2'b11) mbits.push_back(d[8]);
            mbits.push_back(1'b1);
            if (two_stop) mbits.push_back(1'b1);
            mbrk = 0;
          end
          mbusy = 1;
        end
        if (push) mq.push_back(wr_data);
      end
    end
  end

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (%s) t=%0t got %b expected %b", req, phase, $time, act, exp);
    end
  endtask

  // compare every cycle, away from the edge
  always @(posedge clk) begin
    #3;
    if (rst_n && !finished) begin
      chk(txd, (mbusy ? mbits[0] : 1'b1) ^ idle_inv, "R4 txd");
      chk(buf_full, mq.size() == 4, "R1 buf_full");
      chk(wr_ready, tx_en && mq.size() < 4, "R1 wr_ready");
      chk(shift_empty, !mbusy && mq.size() == 0, "R3 shift_empty");
      chk(tx_irq, mirq, "R7 tx_irq");
      chk(brk_busy, mpend, "R9 brk_busy");
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] d);
    wr_data = d; wr_valid = 1'b1;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (!(shift_empty && !brk_busy)) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired (%s)", phase);
      summary();
    end
  end

  initial begin
    rst_n = 0; tx_en = 0; two_stop = 0; idle_inv = 0; brk_go = 0;
    wr_valid = 0; wr_data = '0; frame_fmt = 2'b00; irq_mode = 2'b11;
    cyc(4);
    // R12: reset state
    chk(txd, 1'b1, "R12 txd");
    chk(shift_empty, 1'b1, "R12 shift_empty");
    chk(buf_full, 1'b0, "R12 buf_full");
    chk(tx_irq, 1'b0, "R12 tx_irq");
    chk(brk_busy, 1'b0, "R12 brk_busy");
    rst_n = 1;
    cyc(2);

    phase = "R8 enable interrupt";
    tx_en = 1;
    cyc(6);

    phase = "R1 R2 R4 R6 fill queue";
    irq_mode = 2'b00; tick_div = 3;
    for (int i = 0; i < 5; i++) send(9'(8'hA5 + 8'(i * 37)));
    wr_data = 9'h1FF; wr_valid = 1'b1; cyc(25); wr_valid = 1'b0;
    wait_idle(); cyc(3);

    phase = "R5 R7 formats and modes";
    tick_div = 2;
    for (int f = 1; f < 4; f++) begin
      frame_fmt = 2'(f); two_stop = f[0];
      irq_mode = (f == 1) ? 2'b01 : ((f == 2) ? 2'b10 : 2'b00);
      send(9'h13C); send(9'h0F1); send(9'h1A2);
      wait_idle(); cyc(3);
    end
    irq_mode = 2'b11; frame_fmt = 2'b00; two_stop = 1;
    send(9'h055); send(9'h0AA); wait_idle(); cyc(3);

    phase = "R9 break";
    irq_mode = 2'b01; two_stop = 0;
    send(9'h081); brk_go = 1; cyc(1); brk_go = 0;
    send(9'h07E); wait_idle(); cyc(2);
    brk_go = 1; cyc(1); brk_go = 0; wait_idle(); cyc(3);

    phase = "R10 abort";
    send(9'h011); send(9'h022); send(9'h033);
    brk_go = 1; cyc(1); brk_go = 0;
    cyc(15); tx_en = 0; cyc(3); tx_en = 1; cyc(4);
    send(9'h044); wait_idle(); cyc(3);

    phase = "R11 inverted idle";
    idle_inv = 1; frame_fmt = 2'b01;
    send(9'h0C3); send(9'h03C); wait_idle(); cyc(3);
    idle_inv = 0; frame_fmt = 2'b00;

    phase = "R3 R7 write on closing edge";
    tick_div = 1; irq_mode = 2'b01;
    for (int k = 0; k < 25; k++) begin
      send(9'(k * 11)); cyc(k); send(9'(8'hF0 - 8'(k)));
      wait_idle(); cyc(2);
    end

    summary();
  end
endmodule